// File: doc/BRIEF.md
# Watchdog Timer with Assignable Prescaler

This block is a watchdog that counts on its own free-running clock, independent of the system clock, so it keeps counting while the system clock is stopped during sleep. A base counter marks a fixed number of watchdog-clock cycles. A shared power-of-two divider can stretch that period by up to 1:128. An owner bit hands the divider either to the watchdog or to a general-purpose timer tick path. Software clears the watchdog with a clear pulse, and entering sleep restarts it in the same way. When the watchdog expires, the block raises a reset request if the device is running, or a wake-up request if it is asleep. In both cases it drives a time-out status flag low.

The clear and sleep-entry pulses come from the system clock domain. They cross into the watchdog domain through a toggle synchronizer. The configuration bits are quasi-static and pass through two-stage synchronizers. An expiry crosses back to the system domain as a toggle, so an expiry that occurs while the system clock is stopped is still delivered once that clock runs again.

Top module: `wdog_unit`

## Requirements
- R1: After reset, `rst_req` and `wake_req` are 0, `to_n` is 1, and `tmr_tick_out` is 0.
- R2: While `in_sleep` is 0, an expiry gives a one-cycle `rst_req` pulse in the system domain. With the divider owned by the watchdog, the expiry comes BASE_CYC × 2^`ratio` watchdog-clock cycles after the restart took effect, plus the synchronizer latency.
- R3: While `in_sleep` is 1, an expiry gives a one-cycle `wake_req` pulse and no `rst_req`.
- R4: While `cfg_en` is 0, the watchdog never expires.
- R5: The `ratio` field is binary PS. With `div_to_timer`=0, the watchdog period is BASE_CYC × 2^PS, so 0 selects 1:1 and 7 selects 1:128.
- R6: With `div_to_timer`=1, the watchdog period is BASE_CYC whatever `ratio` holds. In that case `tmr_tick_out` gives one pulse per 2^PS pulses of `tmr_tick_in`.
- R7: With `div_to_timer`=0, `tmr_tick_out` repeats every `tmr_tick_in` pulse undivided, one watchdog-clock cycle later.
- R8: A `clr_pulse` or a `sleep_pulse` restarts the base count. When `div_to_timer`=0, it also zeroes the divider. Restarts repeated faster than one period prevent any expiry.
- R9: An expiry drives `to_n` to 0. A `clr_pulse` or a `sleep_pulse` sets it back to 1.
- R10: If a clear is issued before `ratio` is lowered, the first expiry comes one full new period after that clear.
- R11: An expiry that occurs while the system clock is stopped is presented on `wake_req` once the system clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may be stopped during sleep |
| wd_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| clr_pulse | input | 1 | Watchdog clear command, one sys_clk cycle |
| sleep_pulse | input | 1 | Sleep-entry command, one sys_clk cycle |
| in_sleep | input | 1 | Device is asleep (selects wake instead of reset) |
| cfg_en | input | 1 | Configuration enable; 0 disables the watchdog |
| div_to_timer | input | 1 | Divider owner: 0 watchdog, 1 timer path |
| ratio | input | 3 | Divide exponent PS, ratio 2^PS |
| tmr_tick_in | input | 1 | Timer-path source tick, watchdog clock domain |
| tmr_tick_out | output | 1 | Timer-path tick, divided when the timer owns the divider |
| rst_req | output | 1 | Device reset request pulse, system domain |
| wake_req | output | 1 | Wake-up request pulse, system domain |
| to_n | output | 1 | Time-out status flag, low after an expiry |

## Verification
The bench measures the time from a restart to the request at several divide exponents. A divider that is off by one stage, or one that ignores the owner bit, would make the period double or halve. The bench lowers the ratio after the divider has counted partway, with a clear issued first. A design that does not zero the divider on a clear would expire within a base period instead of a full new period. The bench stops the system clock across an expiry during sleep. A level or pulse crossing, instead of a toggle, would lose that wake event. It also keeps restarting the watchdog faster than one period, and it holds the enable low. A restart that fails to zero the base counter, or an enable that is not honoured, would show up there as a stray reset.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int PS_W  = 3;
  localparam int DIV_W = (1 << PS_W) - 1;

  localparam logic OWN_WDT = 1'b0;
  localparam logic OWN_TMR = 1'b1;

  // Low PS bits set: the divider fires when these bits of its count are all ones.
  function automatic logic [DIV_W-1:0] ratio_mask(input logic [PS_W-1:0] ps);
    logic [DIV_W:0] one;
    logic [DIV_W:0] span;
    one  = (DIV_W+1)'(1);
    span = (one << ps) - one;
    return span[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
`timescale 1ns/1ps
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_bit_sync.sv
`timescale 1ns/1ps
module wdog_bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wdog_pulse_xing.sv
`timescale 1ns/1ps
module wdog_pulse_xing #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic tgl_q, tgl_d;
  logic tgl_sync;
  logic seen_q;

  always_comb tgl_d = tgl_q ^ src_pulse;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  wdog_bit_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (tgl_q),
    .q     (tgl_sync)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= tgl_sync;
  end

  assign dst_pulse = tgl_sync ^ seen_q;
endmodule

// File: rtl/wdog_base_cnt.sv
`timescale 1ns/1ps
module wdog_base_cnt #(
  parameter int BASE_CYC = 18000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        restart,
  output logic                        tick,
  output logic [$clog2(BASE_CYC)-1:0] count
);
  localparam int CW = $clog2(BASE_CYC);
  localparam logic [CW-1:0] LAST = CW'(BASE_CYC - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run & ~restart & at_last;

  always_comb begin
    cnt_en = restart | run | (|cnt_q);
    if (restart || !run) cnt_d = '0;
    else if (at_last)    cnt_d = '0;
    else                 cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_divider.sv
`timescale 1ns/1ps
module wdog_divider
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [PS_W-1:0]  ps,
  output logic             tick_out,
  output logic [DIV_W-1:0] count
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask;
  logic             cnt_en;

  assign mask     = ratio_mask(ps);
  assign tick_out = tick_in & ~clr & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_en = clr | tick_in;
    cnt_d  = clr ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_unit.sv
`timescale 1ns/1ps
module wdog_unit
  import wdog_pkg::*;
#(
  parameter int BASE_CYC    = 18000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            sys_clk,
  input  logic            wd_clk,
  input  logic            rst_n,
  input  logic            clr_pulse,
  input  logic            sleep_pulse,
  input  logic            in_sleep,
  input  logic            cfg_en,
  input  logic            div_to_timer,
  input  logic [PS_W-1:0] ratio,
  input  logic            tmr_tick_in,
  output logic            tmr_tick_out,
  output logic            rst_req,
  output logic            wake_req,
  output logic            to_n
);
  localparam int CW     = $clog2(BASE_CYC);
  localparam int CFG_W  = PS_W + 2;

  // Reset release per domain
  logic sys_rst_n, wd_rst_n;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(sys_clk), .arst_n(rst_n), .srst_n(sys_rst_n));
  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_wd (
    .clk(wd_clk), .arst_n(rst_n), .srst_n(wd_rst_n));

  // Restart command: clear and sleep entry act alike on the counters
  logic restart_sys, restart_wd;
  assign restart_sys = clr_pulse | sleep_pulse;

  wdog_pulse_xing #(.STAGES(SYNC_STAGES)) u_restart_xing (
    .src_clk(sys_clk), .src_rst_n(sys_rst_n), .src_pulse(restart_sys),
    .dst_clk(wd_clk),  .dst_rst_n(wd_rst_n),  .dst_pulse(restart_wd));

  // Quasi-static configuration into the watchdog domain
  logic [CFG_W-1:0] cfg_wd;
  logic             en_wd, owner_wd;
  logic [PS_W-1:0]  ps_wd;

  wdog_bit_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk(wd_clk), .rst_n(wd_rst_n),
    .d({cfg_en, div_to_timer, ratio}), .q(cfg_wd));

  assign {en_wd, owner_wd, ps_wd} = cfg_wd;

  // Base period
  logic          base_tick;
  logic [CW-1:0] base_cnt;

  wdog_base_cnt #(.BASE_CYC(BASE_CYC)) u_base (
    .clk(wd_clk), .rst_n(wd_rst_n), .run(en_wd), .restart(restart_wd),
    .tick(base_tick), .count(base_cnt));

  // Shared divider
  logic             div_in, div_clr, div_tick;
  logic [DIV_W-1:0] div_cnt;

  always_comb begin
    div_in  = (owner_wd == OWN_WDT) ? base_tick : tmr_tick_in;
    div_clr = restart_wd & (owner_wd == OWN_WDT);
  end

  wdog_divider u_div (
    .clk(wd_clk), .rst_n(wd_rst_n), .clr(div_clr), .tick_in(div_in),
    .ps(ps_wd), .tick_out(div_tick), .count(div_cnt));

  // Expiry and timer-path tick
  logic wd_timeout;
  logic tmr_out_q, tmr_out_d;

  always_comb begin
    wd_timeout = en_wd & ((owner_wd == OWN_TMR) ? base_tick : div_tick);
    tmr_out_d  = (owner_wd == OWN_TMR) ? div_tick : tmr_tick_in;
  end

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) tmr_out_q <= 1'b0;
    else           tmr_out_q <= tmr_out_d;
  end

  assign tmr_tick_out = tmr_out_q;

  // Expiry back to the system domain
  logic to_sys;

  wdog_pulse_xing #(.STAGES(SYNC_STAGES)) u_expiry_xing (
    .src_clk(wd_clk),  .src_rst_n(wd_rst_n),  .src_pulse(wd_timeout),
    .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(to_sys));

  logic rst_q, rst_d, wake_q, wake_d, ton_q, ton_d, ton_en;

  always_comb begin
    rst_d  = to_sys & ~in_sleep;
    wake_d = to_sys & in_sleep;
    ton_en = to_sys | restart_sys;
    ton_d  = ~to_sys;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
      ton_q  <= 1'b1;
    end else begin
      rst_q  <= rst_d;
      wake_q <= wake_d;
      if (ton_en) ton_q <= ton_d;
    end
  end

  assign rst_req  = rst_q;
  assign wake_req = wake_q;
  assign to_n     = ton_q;
endmodule

// File: rtl/wdog_unit_chk.sv
`timescale 1ns/1ps
module wdog_unit_chk #(
  parameter int BASE_CYC = 18000
) (
  input logic                        wd_clk,
  input logic                        wd_rst_n,
  input logic                        sys_clk,
  input logic                        sys_rst_n,
  input logic                        restart_wd,
  input logic                        owner_wd,
  input logic                        en_wd,
  input logic                        wd_timeout,
  input logic [$clog2(BASE_CYC)-1:0] base_cnt,
  input logic [6:0]                  div_cnt,
  input logic                        to_sys,
  input logic                        restart_sys,
  input logic                        in_sleep,
  input logic                        rst_req,
  input logic                        wake_req,
  input logic                        to_n
);
  a_r8_base_restart: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    restart_wd |=> (base_cnt == '0));

  a_r8_div_restart: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (restart_wd && !owner_wd) |=> (div_cnt == '0));

  a_r4_disabled_silent: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    !en_wd |-> !wd_timeout);

  a_r2_base_bound: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    32'(base_cnt) < BASE_CYC);

  a_r2_expiry_delivered: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    to_sys |=> (rst_req || wake_req));

  a_r3_no_reset_asleep: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (to_sys && in_sleep) |=> (wake_req && !rst_req));

  a_r9_flag_low: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    to_sys |=> !to_n);

  a_r9_flag_set: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (restart_sys && !to_sys) |=> to_n);
endmodule

bind wdog_unit wdog_unit_chk #(.BASE_CYC(BASE_CYC)) u_chk (
  .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
  .restart_wd(restart_wd), .owner_wd(owner_wd), .en_wd(en_wd),
  .wd_timeout(wd_timeout), .base_cnt(base_cnt), .div_cnt(div_cnt),
  .to_sys(to_sys), .restart_sys(restart_sys), .in_sleep(in_sleep),
  .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n));

// File: tb/wdog_unit_tb.sv
`timescale 1ns/1ps
module wdog_unit_tb;
  localparam int     BASE = 16;
  localparam longint WDP  = 40;
  localparam longint SLACK = 320;

  logic sys_clk, wd_clk, sys_run;
  logic rst_n, clr_pulse, sleep_pulse, in_sleep, cfg_en, div_to_timer, tmr_tick_in;
  logic [2:0] ratio;
  logic tmr_tick_out, rst_req, wake_req, to_n;

  int checks, errors, n_rst, n_wake, n_tout;
  time t_rst, t_wake;
  bit done;

  initial begin sys_clk = 1'b0; wd_clk = 1'b0; sys_run = 1'b1; end
  always begin #4; if (sys_run) sys_clk = ~sys_clk; end
  always #20 wd_clk = ~wd_clk;

  wdog_unit #(.BASE_CYC(BASE)) u_dut (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .rst_n(rst_n), .clr_pulse(clr_pulse),
    .sleep_pulse(sleep_pulse), .in_sleep(in_sleep), .cfg_en(cfg_en),
    .div_to_timer(div_to_timer), .ratio(ratio), .tmr_tick_in(tmr_tick_in),
    .tmr_tick_out(tmr_tick_out), .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n));

  always @(negedge sys_clk) begin
    if (rst_req)  begin n_rst++;  t_rst  = $time; end
    if (wake_req) begin n_wake++; t_wake = $time; end
  end
  always @(negedge wd_clk) if (tmr_tick_out) n_tout++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_wd(input int n);
    repeat (n) @(negedge wd_clk);
  endtask

  task automatic pulse(input bit use_sleep);
    @(negedge sys_clk);
    if (use_sleep) sleep_pulse = 1'b1; else clr_pulse = 1'b1;
    @(negedge sys_clk);
    sleep_pulse = 1'b0; clr_pulse = 1'b0;
  endtask

  // Restart, optionally change ratio after hold_wd cycles, time the first request
  task automatic restart_and_time(input bit use_sleep, input bit pre, input int hold_wd,
                                  input logic [2:0] new_ratio, output longint dt);
    int c0;
    time t0;
    if (pre) begin pulse(1'b0); wait_wd(8); end
    c0 = use_sleep ? n_wake : n_rst;
    @(negedge sys_clk);
    if (use_sleep) sleep_pulse = 1'b1; else clr_pulse = 1'b1;
    t0 = $time;
    @(negedge sys_clk);
    sleep_pulse = 1'b0; clr_pulse = 1'b0;
    if (hold_wd > 0) begin wait_wd(hold_wd); ratio = new_ratio; end
    dt = -1;
    for (int i = 0; i < 30000; i++) begin
      @(negedge sys_clk);
      if ((use_sleep ? n_wake : n_rst) != c0) begin
        dt = longint'(use_sleep ? t_wake : t_rst) - longint'(t0);
        break;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_wd(5);
    rst_n = 1'b1;
    wait_wd(4);
    chk(rst_req == 1'b0, "R1", "rst_req after reset", longint'(rst_req), 0);
    chk(wake_req == 1'b0, "R1", "wake_req after reset", longint'(wake_req), 0);
    chk(to_n == 1'b1, "R1", "to_n after reset", longint'(to_n), 1);
    chk(tmr_tick_out == 1'b0, "R1", "tmr_tick_out after reset", longint'(tmr_tick_out), 0);
  endtask

  task automatic t_base_period;
    longint dt, e;
    ratio = 3'd0; wait_wd(6);
    restart_and_time(1'b0, 1'b1, 0, 3'd0, dt);
    e = BASE * WDP;
    chk(dt >= e && dt <= e + SLACK, "R2", "awake period ps0 (ns, min shown)", dt, e);
    chk(to_n == 1'b0, "R9", "to_n after expiry", longint'(to_n), 0);
    pulse(1'b0);
    @(negedge sys_clk);
    chk(to_n == 1'b1, "R9", "to_n after clear", longint'(to_n), 1);
  endtask

  task automatic t_ratio(input logic [2:0] ps);
    longint dt, e;
    ratio = ps; wait_wd(6);
    restart_and_time(1'b0, 1'b1, 0, 3'd0, dt);
    e = (BASE * WDP) << ps;
    chk(dt >= e && dt <= e + SLACK, "R5", $sformatf("period ps%0d (ns, min shown)", ps), dt, e);
  endtask

  task automatic t_clear_holds;
    int c0r, c0w;
    ratio = 3'd0; wait_wd(6);
    pulse(1'b0); wait_wd(8);
    c0r = n_rst; c0w = n_wake;
    for (int i = 0; i < 8; i++) begin
      pulse(i[0]);
      wait_wd(10);
    end
    chk(n_rst == c0r && n_wake == c0w, "R8", "requests during repeated restarts",
        longint'(n_rst - c0r + n_wake - c0w), 0);
  endtask

  task automatic t_sleep_wake;
    longint dt, e;
    int c0r;
    in_sleep = 1'b1; wait_wd(8);
    c0r = n_rst;
    restart_and_time(1'b1, 1'b1, 0, 3'd0, dt);
    e = BASE * WDP;
    chk(dt >= e && dt <= e + SLACK, "R3", "asleep wake period (ns, min shown)", dt, e);
    chk(n_rst == c0r, "R3", "reset requests while asleep", longint'(n_rst - c0r), 0);
    in_sleep = 1'b0;
    pulse(1'b0); wait_wd(8);
  endtask

  task automatic t_clock_stopped;
    int c0r, c0w;
    in_sleep = 1'b1;
    pulse(1'b0); wait_wd(8);
    c0r = n_rst; c0w = n_wake;
    pulse(1'b1);
    repeat (2) @(negedge sys_clk);
    sys_run = 1'b0;
    #1000;
    sys_run = 1'b1;
    repeat (12) @(negedge sys_clk);
    chk(n_wake - c0w == 1, "R11", "wake after clock restart", longint'(n_wake - c0w), 1);
    chk(n_rst == c0r, "R11", "reset requests across stop", longint'(n_rst - c0r), 0);
    in_sleep = 1'b0;
    pulse(1'b0); wait_wd(8);
  endtask

  task automatic t_disabled;
    int c0r, c0w;
    cfg_en = 1'b0; wait_wd(10);
    c0r = n_rst; c0w = n_wake;
    pulse(1'b0);
    wait_wd(BASE * 4);
    chk(n_rst == c0r && n_wake == c0w, "R4", "requests while disabled",
        longint'(n_rst - c0r + n_wake - c0w), 0);
    cfg_en = 1'b1; wait_wd(6);
  endtask

  task automatic t_timer_owner;
    longint dt, e;
    int c0;
    div_to_timer = 1'b1; ratio = 3'd2; wait_wd(6);
    restart_and_time(1'b0, 1'b1, 0, 3'd0, dt);
    e = BASE * WDP;
    chk(dt >= e && dt <= e + SLACK, "R6", "period with timer owning divider (ns)", dt, e);
    c0 = n_tout;
    for (int i = 0; i < 16; i++) begin
      @(negedge wd_clk); tmr_tick_in = 1'b1;
      @(negedge wd_clk); tmr_tick_in = 1'b0;
    end
    wait_wd(3);
    chk(n_tout - c0 == 4, "R6", "timer ticks out of 16 at ps2", longint'(n_tout - c0), 4);
  endtask

  task automatic t_wdt_owner_pass;
    int c0;
    div_to_timer = 1'b0; ratio = 3'd2; wait_wd(6);
    c0 = n_tout;
    for (int i = 0; i < 5; i++) begin
      @(negedge wd_clk); tmr_tick_in = 1'b1;
      @(negedge wd_clk); tmr_tick_in = 1'b0;
    end
    wait_wd(3);
    chk(n_tout - c0 == 5, "R7", "undivided timer ticks", longint'(n_tout - c0), 5);
  endtask

  task automatic t_ratio_change;
    longint dt, e;
    ratio = 3'd3; wait_wd(6);
    pulse(1'b0);
    wait_wd(BASE * 5 + 8);
    restart_and_time(1'b0, 1'b0, 6, 3'd1, dt);
    e = (BASE * WDP) << 1;
    chk(dt >= e && dt <= e + SLACK, "R10", "period after clear then ratio drop (ns)", dt, e);
  endtask

  initial begin
    checks = 0; errors = 0; n_rst = 0; n_wake = 0; n_tout = 0; done = 1'b0;
    t_rst = 0; t_wake = 0;
    rst_n = 1'b0; clr_pulse = 1'b0; sleep_pulse = 1'b0; in_sleep = 1'b0;
    cfg_en = 1'b1; div_to_timer = 1'b0; ratio = 3'd0; tmr_tick_in = 1'b0;
    t_reset();
    t_base_period();
    t_ratio(3'd3);
    t_ratio(3'd7);
    t_clear_holds();
    t_sleep_wake();
    t_clock_stopped();
    t_disabled();
    t_timer_owner();
    t_wdt_owner_pass();
    t_ratio_change();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule